// File: doc/BRIEF.md
# Short Conditional Branch Resolver

This block resolves the short relative jump group of a 16-bit core whose program counter is 22 bits wide. That counter is a 16-bit PC word plus a 6-bit code page. The caller presents one instruction word with `valid_i` high. With it come the four status flags (negative, zero, sign, carry), the PC of the word after the branch and the current page. One clock later the block reports three things. The first is whether the word belongs to the jump group. The second is whether the branch is taken. The third is the PC and page to continue from and the number of cycles the branch costs.

A taken branch moves the 22-bit address by an unsigned 6-bit magnitude. A separate opcode bit chooses forward or backward. Carries and borrows run across the 16-bit boundary into the page field, and the result wraps modulo 2^22. Words outside the group are flagged and pass the PC and page through unchanged. Far jumps, calls and instruction fetch are handled elsewhere.

Top module: `bru_core`

## Requirements
- R1: A word is in the group only when bits 15:12 hold a code in 0..11 or 14, bits 11:9 equal 7 and bits 8:6 equal 0 or 1. Any other word (including codes 12, 13 and 15) sets `not_group_o`=1, `taken_o`=0 and `cost_o`=0, and returns the supplied PC and page unchanged.
- R2: For a taken branch the offset is bits 5:0 taken as unsigned. It is added when bit 6 is 0 and subtracted when bit 6 is 1 (bits 8:7 are 0 in the group).
- R3: Codes 0..7 take the branch respectively when: C=0, C=1, S=0, S=1, Z=0, Z=1, N=0, N=1.
- R4: Code 9 takes the branch only when Z=0 and C=1. Code 8 takes it in every other flag state.
- R5: Code 10 takes the branch when Z=1 or S=1. Code 11 takes it when both are 0. Code 14 always takes it.
- R6: The target is ({page,PC} + signed offset) mod 2^22. Bits 15:0 go to `pc_o` and bits 21:16 go to `page_o`, so carries and borrows cross into the page and wrap at the ends of the space.
- R7: `cost_o` is 4 for a taken branch and 2 for a group word whose condition fails.
- R8: A group word whose condition fails gives `taken_o`=0, `not_group_o`=0, and returns the supplied PC and page.
- R9: Results appear on the clock edge after the one that samples `valid_i`=1, with `valid_o`=1. `valid_o` is 0 after a cycle with `valid_i`=0. Reset clears every output to 0.
- R10: While `valid_i` is 0, `taken_o`, `not_group_o`, `pc_o`, `page_o` and `cost_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction word presented this cycle |
| instr_i | input | 16 | Instruction word |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_s_i | input | 1 | Signed-less-than flag |
| flag_c_i | input | 1 | Carry flag |
| pc_i | input | 16 | PC of the word following the branch |
| page_i | input | 6 | Current code page |
| valid_o | output | 1 | Result valid |
| taken_o | output | 1 | Branch taken |
| not_group_o | output | 1 | Word is not a short jump |
| pc_o | output | 16 | Next PC word |
| page_o | output | 6 | Next code page |
| cost_o | output | 4 | Cycle cost of the branch |

## Verification
Every condition code is driven with flag states that both satisfy and fail it. For the compound codes 8 to 11, all four combinations of the two flags involved are used, which separates the AND/OR readings from the single-flag ones. Addresses are placed at the page boundaries with forward and backward offsets, so a dropped carry or borrow into the page, or a missing 22-bit wrap, shows up as a wrong page. Near-miss encodings and long pseudo-random runs are compared every clock against a behavioural model. These include codes 12, 13 and 15, wrong bits 11:9 and bits 8:6 of 2 to 7, together with idle cycles.

// File: rtl/bru_pkg.sv
package bru_pkg;

    typedef enum logic [3:0] {
        CC_CARRY_CLR = 4'd0,
        CC_CARRY_SET = 4'd1,
        CC_SIGN_CLR  = 4'd2,
        CC_SIGN_SET  = 4'd3,
        CC_ZERO_CLR  = 4'd4,
        CC_ZERO_SET  = 4'd5,
        CC_NEG_CLR   = 4'd6,
        CC_NEG_SET   = 4'd7,
        CC_NOT_ABOVE = 4'd8,
        CC_ABOVE     = 4'd9,
        CC_LESS_EQ   = 4'd10,
        CC_GREATER   = 4'd11,
        CC_RSVD_A    = 4'd12,
        CC_RSVD_B    = 4'd13,
        CC_ALWAYS    = 4'd14,
        CC_ESCAPE    = 4'd15
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic s;
        logic c;
    } flags_t;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
#(
    parameter int unsigned INSTR_W = 16,
    parameter int unsigned OFF_W   = 6
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               in_group,
    output cond_e              cond,
    output logic               backward,
    output logic [OFF_W-1:0]   magnitude
);
    localparam int unsigned COND_LSB = INSTR_W - 4;
    localparam int unsigned SEL_LSB  = COND_LSB - 3;
    localparam int unsigned DIR_LSB  = SEL_LSB - 3;

    logic [2:0] sel_field;
    logic [2:0] dir_field;
    logic       code_ok;

    always_comb begin
        cond      = cond_e'(instr[INSTR_W-1:COND_LSB]);
        sel_field = instr[SEL_LSB +: 3];
        dir_field = instr[DIR_LSB +: 3];
        magnitude = instr[OFF_W-1:0];
        backward  = dir_field[0];
        unique case (cond)
            CC_RSVD_A, CC_RSVD_B, CC_ESCAPE: code_ok = 1'b0;
            default:                          code_ok = 1'b1;
        endcase
        in_group = code_ok && (sel_field == 3'd7) && (dir_field[2:1] == 2'b00);
    end

endmodule

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
(
    input  cond_e  cond,
    input  flags_t flags,
    output logic   take
);
    logic above;

    always_comb begin
        above = !flags.z && flags.c;
        unique case (cond)
            CC_CARRY_CLR: take = !flags.c;
            CC_CARRY_SET: take =  flags.c;
            CC_SIGN_CLR:  take = !flags.s;
            CC_SIGN_SET:  take =  flags.s;
            CC_ZERO_CLR:  take = !flags.z;
            CC_ZERO_SET:  take =  flags.z;
            CC_NEG_CLR:   take = !flags.n;
            CC_NEG_SET:   take =  flags.n;
            CC_NOT_ABOVE: take = !above;
            CC_ABOVE:     take =  above;
            CC_LESS_EQ:   take =  flags.z || flags.s;
            CC_GREATER:   take = !(flags.z || flags.s);
            CC_ALWAYS:    take = 1'b1;
            default:      take = 1'b0;
        endcase
    end

endmodule

// File: rtl/bru_target.sv
module bru_target #(
    parameter int unsigned PC_W   = 16,
    parameter int unsigned PAGE_W = 6,
    parameter int unsigned OFF_W  = 6
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [PAGE_W-1:0] page,
    input  logic              backward,
    input  logic [OFF_W-1:0]  magnitude,
    output logic [PC_W-1:0]   pc_next,
    output logic [PAGE_W-1:0] page_next
);
    localparam int unsigned ADDR_W = PC_W + PAGE_W;

    logic [ADDR_W-1:0] linear;
    logic [ADDR_W-1:0] delta;
    logic [ADDR_W-1:0] sum;

    always_comb begin
        linear = {page, pc};
        delta  = {{(ADDR_W-OFF_W){1'b0}}, magnitude};
        if (backward) begin
            delta = ~delta + {{(ADDR_W-1){1'b0}}, 1'b1};
        end
        sum       = linear + delta;
        pc_next   = sum[PC_W-1:0];
        page_next = sum[ADDR_W-1:PC_W];
    end

endmodule

// File: rtl/bru_core.sv
module bru_core
    import bru_pkg::*;
#(
    parameter int unsigned INSTR_W        = 16,
    parameter int unsigned PC_W           = 16,
    parameter int unsigned PAGE_W         = 6,
    parameter int unsigned OFF_W          = 6,
    parameter int unsigned COST_W         = 4,
    parameter int unsigned TAKEN_COST     = 4,
    parameter int unsigned NOT_TAKEN_COST = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic               flag_n_i,
    input  logic               flag_z_i,
    input  logic               flag_s_i,
    input  logic               flag_c_i,
    input  logic [PC_W-1:0]    pc_i,
    input  logic [PAGE_W-1:0]  page_i,
    output logic               valid_o,
    output logic               taken_o,
    output logic               not_group_o,
    output logic [PC_W-1:0]    pc_o,
    output logic [PAGE_W-1:0]  page_o,
    output logic [COST_W-1:0]  cost_o
);
    localparam logic [COST_W-1:0] COST_T  = COST_W'(TAKEN_COST);
    localparam logic [COST_W-1:0] COST_NT = COST_W'(NOT_TAKEN_COST);

    typedef struct packed {
        logic              valid;
        logic              taken;
        logic              not_group;
        logic [PC_W-1:0]   pc;
        logic [PAGE_W-1:0] page;
        logic [COST_W-1:0] cost;
    } res_t;

    res_t st_d, st_q;

    logic              in_group;
    cond_e             cond;
    logic              backward;
    logic [OFF_W-1:0]  magnitude;
    logic              take;
    flags_t            flags;
    logic [PC_W-1:0]   pc_tgt;
    logic [PAGE_W-1:0] page_tgt;

    assign flags = '{n: flag_n_i, z: flag_z_i, s: flag_s_i, c: flag_c_i};

    bru_decode #(.INSTR_W(INSTR_W), .OFF_W(OFF_W)) u_decode (
        .instr     (instr_i),
        .in_group  (in_group),
        .cond      (cond),
        .backward  (backward),
        .magnitude (magnitude)
    );

    bru_cond u_cond (
        .cond  (cond),
        .flags (flags),
        .take  (take)
    );

    bru_target #(.PC_W(PC_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_target (
        .pc        (pc_i),
        .page      (page_i),
        .backward  (backward),
        .magnitude (magnitude),
        .pc_next   (pc_tgt),
        .page_next (page_tgt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = valid_i;
        if (valid_i) begin
            st_d.not_group = !in_group;
            st_d.taken     = in_group && take;
            if (in_group && take) begin
                st_d.pc   = pc_tgt;
                st_d.page = page_tgt;
                st_d.cost = COST_T;
            end else begin
                st_d.pc   = pc_i;
                st_d.page = page_i;
                st_d.cost = in_group ? COST_NT : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o     = st_q.valid;
    assign taken_o     = st_q.taken;
    assign not_group_o = st_q.not_group;
    assign pc_o        = st_q.pc;
    assign page_o      = st_q.page;
    assign cost_o      = st_q.cost;

    // R1
    wrong_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[INSTR_W-5 -: 3] != 3'd7) |=> (not_group_o && !taken_o && cost_o == '0));

    // R5
    always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && instr_i[INSTR_W-1 -: 4] == 4'd14 && instr_i[INSTR_W-5 -: 3] == 3'd7
         && instr_i[INSTR_W-8 -: 2] == 2'b00) |=> taken_o);

    // R7
    taken_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && taken_o) |-> (cost_o == COST_T));

    // R8
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> (taken_o || (pc_o == $past(pc_i) && page_o == $past(page_i))));

    // R9
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && $stable(pc_o) && $stable(page_o) && $stable(taken_o)
                      && $stable(cost_o) && $stable(not_group_o)));

endmodule

// File: tb/sim_bru_core.sv
module sim_bru_core;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic        flag_n_i = 1'b0, flag_z_i = 1'b0, flag_s_i = 1'b0, flag_c_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic [5:0]  page_i = '0;
    logic        valid_o, taken_o, not_group_o;
    logic [15:0] pc_o;
    logic [5:0]  page_o;
    logic [3:0]  cost_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    // reference state
    logic        e_v = 0, e_t = 0, e_ng = 0;
    logic [15:0] e_pc = 0;
    logic [5:0]  e_pg = 0;
    logic [3:0]  e_cost = 0;

    always #(CLK_P/2) clk = ~clk;

    bru_core u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .instr_i(instr_i),
        .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .flag_s_i(flag_s_i), .flag_c_i(flag_c_i),
        .pc_i(pc_i), .page_i(page_i), .valid_o(valid_o), .taken_o(taken_o),
        .not_group_o(not_group_o), .pc_o(pc_o), .page_o(page_o), .cost_o(cost_o)
    );

    function automatic logic [15:0] mk(input int code, input int dir, input int mag);
        return {4'(code), 3'd7, 3'(dir), 6'(mag)};
    endfunction

    function automatic bit cond_true(input int code, input bit n, z, s, c);
        case (code)
            0: return !c;
            1: return c;
            2: return !s;
            3: return s;
            4: return !z;
            5: return z;
            6: return !n;
            7: return n;
            8: return !(z == 0 && c == 1);
            9: return (z == 0 && c == 1);
            10: return z || s;
            11: return !z && !s;
            14: return 1;
            default: return 0;
        endcase
    endfunction

    task automatic compare(input string tag);
        logic [44:0] got, exp;
        got = {valid_o, taken_o, not_group_o, pc_o, page_o, cost_o, 14'd0};
        exp = {e_v, e_t, e_ng, e_pc, e_pg, e_cost, 14'd0};
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual v=%0b t=%0b ng=%0b pc=%h pg=%h cost=%0d expected v=%0b t=%0b ng=%0b pc=%h pg=%h cost=%0d",
                     tag, valid_o, taken_o, not_group_o, pc_o, page_o, cost_o,
                     e_v, e_t, e_ng, e_pc, e_pg, e_cost);
        end
    endtask

    // called at a falling edge; compares at the next falling edge
    task automatic apply(input bit v, input logic [15:0] ins, input logic [3:0] nzsc,
                         input logic [15:0] pc, input logic [5:0] pg, input string tag);
        int code, lin;
        bit grp;
        valid_i = v; instr_i = ins; pc_i = pc; page_i = pg;
        {flag_n_i, flag_z_i, flag_s_i, flag_c_i} = nzsc;
        e_v = v;
        if (v) begin
            code = int'(ins[15:12]);
            grp = (code <= 11 || code == 14) && ins[11:9] == 3'd7 && ins[8:6] <= 3'd1;
            if (!grp) begin
                e_ng = 1; e_t = 0; e_pc = pc; e_pg = pg; e_cost = 0;
            end else if (cond_true(code, nzsc[3], nzsc[2], nzsc[1], nzsc[0])) begin
                lin = int'(pg) * 65536 + int'(pc);
                if (ins[6]) lin = lin - int'(ins[5:0]);
                else        lin = lin + int'(ins[5:0]);
                lin = lin & 32'h003F_FFFF;
                e_ng = 0; e_t = 1; e_pc = 16'(lin); e_pg = 6'(lin >>> 16); e_cost = 4;
            end else begin
                e_ng = 0; e_t = 0; e_pc = pc; e_pg = pg; e_cost = 2;
            end
        end
        @(negedge clk);
        compare(tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        compare("R9 reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R9 idle after reset");

        // R3: single-flag codes, each satisfied and failed
        for (int cc = 0; cc < 8; cc++) begin
            apply(1, mk(cc, 0, 5), 4'b0000, 16'h1000, 6'h02, "R3 flags clear");
            apply(1, mk(cc, 1, 7), 4'b1111, 16'h1000, 6'h02, "R3 flags set");
        end
        // R4 / R5: compound codes over all Z,C and Z,S pairs
        for (int f = 0; f < 4; f++) begin
            apply(1, mk(8, 0, 3), {1'b0, 1'(f >> 1), 1'b0, 1'(f)}, 16'h0200, 6'h00, "R4 code8");
            apply(1, mk(9, 0, 3), {1'b0, 1'(f >> 1), 1'b0, 1'(f)}, 16'h0200, 6'h00, "R4 code9");
            apply(1, mk(10, 1, 3), {1'b0, 1'(f >> 1), 1'(f), 1'b0}, 16'h0200, 6'h00, "R5 code10");
            apply(1, mk(11, 1, 3), {1'b0, 1'(f >> 1), 1'(f), 1'b0}, 16'h0200, 6'h00, "R5 code11");
            apply(1, mk(14, f & 1, 63), 4'(f * 5), 16'h0200, 6'h00, "R5 always");
        end
        // R2: direction and full magnitude
        apply(1, mk(14, 0, 63), 4'b0, 16'h0100, 6'h05, "R2 forward 63");
        apply(1, mk(14, 1, 63), 4'b0, 16'h0100, 6'h05, "R2 backward 63");
        apply(1, mk(14, 0, 0), 4'b0, 16'h0100, 6'h05, "R2 zero offset");
        // R6: page carry, borrow and 22-bit wrap
        apply(1, mk(14, 0, 2), 4'b0, 16'hFFFF, 6'h00, "R6 carry into page");
        apply(1, mk(14, 1, 1), 4'b0, 16'h0000, 6'h07, "R6 borrow from page");
        apply(1, mk(14, 1, 4), 4'b0, 16'h0001, 6'h00, "R6 wrap low");
        apply(1, mk(14, 0, 1), 4'b0, 16'hFFFF, 6'h3F, "R6 wrap high");
        // R7 / R8: not-taken cost and pass-through
        apply(1, mk(5, 0, 9), 4'b0000, 16'hABCD, 6'h11, "R8 not taken hold");
        apply(1, mk(5, 0, 9), 4'b0100, 16'hABCD, 6'h11, "R7 taken cost");
        apply(1, mk(4, 0, 9), 4'b0100, 16'h1234, 6'h22, "R7 not-taken cost");
        // R1: encodings outside the group
        apply(1, mk(12, 0, 4), 4'b1111, 16'h4000, 6'h01, "R1 code12");
        apply(1, mk(13, 0, 4), 4'b1111, 16'h4000, 6'h01, "R1 code13");
        apply(1, mk(15, 0, 4), 4'b1111, 16'h4000, 6'h01, "R1 code15");
        apply(1, 16'h0C04, 4'b0000, 16'h4000, 6'h01, "R1 select 6");
        apply(1, {4'd14, 3'd7, 3'd2, 6'd4}, 4'b0, 16'h4000, 6'h01, "R1 dir 2");
        apply(1, {4'd14, 3'd7, 3'd7, 6'd4}, 4'b0, 16'h4000, 6'h01, "R1 dir 7");
        // R10: hold while idle
        apply(1, mk(14, 0, 8), 4'b0, 16'h7000, 6'h09, "R9 load");
        apply(0, mk(12, 0, 1), 4'b0, 16'h0000, 6'h00, "R10 idle");
        apply(0, mk(14, 1, 1), 4'b1010, 16'h5555, 6'h2A, "R10 idle 2");
        // pseudo-random run
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] a, b;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            b = lfsr;
            if (a[0]) a[11:9] = 3'd7;
            if (a[1]) a[8:7] = 2'b00;
            apply(b[15:14] != 2'b00, a, b[3:0], b ^ a, b[9:4], "R6 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule